// File: doc/BRIEF.md
# Branch Prediction History Queue

This block keeps an ordered record of every control instruction that the fetch-time predictor has made a guess for and that has not yet retired. Each record carries the instruction's sequence number, its PC, the guessed direction and target, its call, return and indirect flags, whether it consumed or pushed a return-stack entry, and the stack index and target saved for later repair. Fetch appends records at the young end through a valid/ready port. Records leave from either end. Commit drains them from the old end and sends training updates to the direction predictor. A squash drops them from the young end and sends return-stack repair commands.

A squash can be flagged as a mispredict. When the younger records are gone, the record left at the young end must be the branch that was mispredicted. The block rewrites that record with the real outcome and sends a corrective training update. If the branch was taken it also writes the branch target buffer; if it was not taken it repairs the return stack. The predictors and the stack are outside the block. Their command outputs are single-cycle valid pulses that the receivers must accept on the cycle they appear.

The insert port follows valid/ready rules. A record is taken on a cycle where `ins_valid` and `ins_ready` are both high. `ins_ready` is low in any of these cases:
- the queue is full;
- a walk is in progress;
- a commit or squash request is present on the same cycle.

While `ins_ready` is low, the producer holds its record stable. Commit and squash requests are single-cycle pulses, sampled only while `busy` is low. If both arrive together, squash wins.

Top module: `bp_hist_queue`

## Requirements
- R1: After reset the queue is empty, `ins_ready` is 1, `busy` is 0 and every command valid (`trn_valid`, `btb_valid`, `rst_valid`, `pop_valid`, `align_err`) is 0.
- R2: A record is stored when `ins_valid` and `ins_ready` are both 1. Records are kept in arrival order. With 16 records held, `ins_ready` is 0 and offered records are not stored.
- R3: A commit with number D retires records from the old end, one per cycle, while the oldest record's sequence number is ≤ D as a 16-bit unsigned compare. Each retired record produces one `trn_valid` pulse with `trn_squash`=0 and the record's PC, direction and target.
- R4: A squash with number S removes records from the young end, one per cycle, while the youngest record's sequence number is > S (unsigned), youngest first. For each removed record:
  - if it used the stack, it sends `rst_valid` with its saved index and target;
  - otherwise, if it is a call that pushed, it sends `pop_valid`;
  - otherwise it sends nothing.
- R5: For a mispredict whose young-end survivor has sequence number S, the survivor's direction and target are overwritten with `sq_taken`/`sq_target`. One `trn_valid` pulse with `trn_squash`=1 carries its PC, the real direction and the corrected target. A later commit of that record reports the corrected values.
- R6: When the mispredicted branch was taken, `btb_valid` is pulsed with its PC and the corrected target. If it is a return that had not used the stack, its used-stack flag becomes 1, so a later squash that removes it sends a restore.
- R7: When the mispredicted branch was not taken and it used the stack, a restore is sent and its used-stack flag is cleared. Otherwise, if it is a call that pushed, `pop_valid` is sent and its pushed flag is cleared. A later squash that removes the record then sends no stack command.
- R8: If a mispredict's young-end survivor has a sequence number different from S, `align_err` pulses once and no training, buffer or stack command is sent for it.
- R9: A mispredict that finds the queue empty after its walk sends no command of any kind.
- R10: `busy` is 1 from the cycle after a commit or squash is accepted until its walk finishes, and `ins_ready` is 0 throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Insert record offered |
| ins_ready | output | 1 | Insert record can be taken |
| ins_seq | input | 16 | Sequence number of the record |
| ins_pc | input | 32 | PC of the control instruction |
| ins_taken | input | 1 | Predicted direction (1 = taken) |
| ins_target | input | 32 | Predicted target |
| ins_call | input | 1 | Instruction is a call |
| ins_ret | input | 1 | Instruction is a return |
| ins_ind | input | 1 | Instruction is an indirect branch |
| ins_used_stk | input | 1 | Prediction took its target from the return stack |
| ins_pushed_stk | input | 1 | Prediction pushed the return stack |
| ins_stk_idx | input | 4 | Saved return-stack top index |
| ins_stk_tgt | input | 32 | Saved return-stack top target |
| cmt_valid | input | 1 | Commit request pulse |
| cmt_seq | input | 16 | Youngest sequence number to retire |
| sq_valid | input | 1 | Squash request pulse |
| sq_seq | input | 16 | Sequence number of the squash point |
| sq_mispred | input | 1 | Squash is a mispredict of the record at the squash point |
| sq_taken | input | 1 | Real direction of the mispredicted branch |
| sq_target | input | 32 | Corrected target of the mispredicted branch |
| busy | output | 1 | A commit or squash walk is in progress |
| trn_valid | output | 1 | Direction-predictor training pulse |
| trn_pc | output | 32 | PC of the trained branch |
| trn_taken | output | 1 | Direction to train |
| trn_target | output | 32 | Target carried with the training |
| trn_ind | output | 1 | Trained branch is indirect |
| trn_squash | output | 1 | Training comes from a mispredict (1) or commit (0) |
| btb_valid | output | 1 | Target-buffer write pulse |
| btb_pc | output | 32 | PC to write in the target buffer |
| btb_target | output | 32 | Target to write |
| rst_valid | output | 1 | Return-stack restore pulse |
| rst_idx | output | 4 | Stack index to restore |
| rst_tgt | output | 32 | Stack target to restore |
| pop_valid | output | 1 | Return-stack undo-push pulse |
| align_err | output | 1 | Mispredict survivor did not match the squash number |

## Verification
The flags of each record are computed from its sequence-number bits. Each batch of sixteen therefore mixes four kinds of record:
- calls that pushed;
- returns with and without the stack;
- plain branches;
- indirect branches.

The numbers are spaced three apart and sit above 0x8000, so any compare that is signed, or that uses ≥ instead of >, retires or removes a different set of records.

The squash points are swept across every depth of a full queue. The squash kinds alternate: plain squash, taken mispredict and not-taken mispredict. Together these tell apart restore from undo-push selection, the btb write, and the flag updates. A follow-up squash just below the corrected record shows whether those flags were really stored. Further cases cover:
- a commit number below the oldest record;
- a deliberately misaligned squash number;
- mispredicts that empty the queue.

// File: rtl/bphq_pkg.sv
package bphq_pkg;
  localparam int SEQ_W  = 16;
  localparam int ADDR_W = 32;
  localparam int SIDX_W = 4;

  typedef struct packed {
    logic [SEQ_W-1:0]  seq;
    logic [ADDR_W-1:0] pc;
    logic              taken;
    logic [ADDR_W-1:0] target;
    logic              is_call;
    logic              is_ret;
    logic              is_ind;
    logic              used_stk;
    logic              pushed_stk;
    logic [SIDX_W-1:0] stk_idx;
    logic [ADDR_W-1:0] stk_tgt;
  } bphq_entry_t;

  typedef enum logic [1:0] {ST_IDLE, ST_COMMIT, ST_SQUASH, ST_FIX} bphq_state_t;
endpackage

// File: rtl/bphq_store.sv
module bphq_store
  import bphq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_ptr,
  input  bphq_entry_t       wr_entry,
  input  logic              fix_en,
  input  logic [PTR_W-1:0]  fix_ptr,
  input  logic              fix_taken,
  input  logic [ADDR_W-1:0] fix_target,
  input  logic              fix_used,
  input  logic              fix_pushed,
  input  logic [PTR_W-1:0]  old_ptr,
  output logic [SEQ_W-1:0]  old_seq,
  output logic [ADDR_W-1:0] old_pc,
  output logic              old_taken,
  output logic [ADDR_W-1:0] old_target,
  output logic              old_ind,
  input  logic [PTR_W-1:0]  yng_ptr,
  output logic [SEQ_W-1:0]  yng_seq,
  output logic [ADDR_W-1:0] yng_pc,
  output logic              yng_call,
  output logic              yng_ret,
  output logic              yng_ind,
  output logic              yng_used,
  output logic              yng_pushed,
  output logic [SIDX_W-1:0] yng_idx,
  output logic [ADDR_W-1:0] yng_stgt
);
  bphq_entry_t mem [DEPTH];

  // One slot written per cycle: a new record, or the correction of the survivor.
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (wr_en && wr_ptr == PTR_W'(i)) begin
        mem[i] <= wr_entry;
      end else if (fix_en && fix_ptr == PTR_W'(i)) begin
        mem[i].taken      <= fix_taken;
        mem[i].target     <= fix_target;
        mem[i].used_stk   <= fix_used;
        mem[i].pushed_stk <= fix_pushed;
      end
    end
  end

  always_comb begin
    old_seq    = mem[old_ptr].seq;
    old_pc     = mem[old_ptr].pc;
    old_taken  = mem[old_ptr].taken;
    old_target = mem[old_ptr].target;
    old_ind    = mem[old_ptr].is_ind;
    yng_seq    = mem[yng_ptr].seq;
    yng_pc     = mem[yng_ptr].pc;
    yng_call   = mem[yng_ptr].is_call;
    yng_ret    = mem[yng_ptr].is_ret;
    yng_ind    = mem[yng_ptr].is_ind;
    yng_used   = mem[yng_ptr].used_stk;
    yng_pushed = mem[yng_ptr].pushed_stk;
    yng_idx    = mem[yng_ptr].stk_idx;
    yng_stgt   = mem[yng_ptr].stk_tgt;
  end
endmodule

// File: rtl/bphq_ctrl.sv
module bphq_ctrl
  import bphq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  output logic              ins_ready,
  input  logic              cmt_valid,
  input  logic [SEQ_W-1:0]  cmt_seq,
  input  logic              sq_valid,
  input  logic [SEQ_W-1:0]  sq_seq,
  input  logic              sq_mispred,
  input  logic              sq_taken,
  input  logic [ADDR_W-1:0] sq_target,
  output logic              busy,
  output logic              wr_en,
  output logic [PTR_W-1:0]  wr_ptr,
  output logic              fix_en,
  output logic [PTR_W-1:0]  fix_ptr,
  output logic              fix_taken,
  output logic [ADDR_W-1:0] fix_target,
  output logic              fix_used,
  output logic              fix_pushed,
  output logic [PTR_W-1:0]  old_ptr,
  input  logic [SEQ_W-1:0]  old_seq,
  input  logic [ADDR_W-1:0] old_pc,
  input  logic              old_taken,
  input  logic [ADDR_W-1:0] old_target,
  input  logic              old_ind,
  output logic [PTR_W-1:0]  yng_ptr,
  input  logic [SEQ_W-1:0]  yng_seq,
  input  logic [ADDR_W-1:0] yng_pc,
  input  logic              yng_call,
  input  logic              yng_ret,
  input  logic              yng_ind,
  input  logic              yng_used,
  input  logic              yng_pushed,
  input  logic [SIDX_W-1:0] yng_idx,
  input  logic [ADDR_W-1:0] yng_stgt,
  output logic              trn_valid,
  output logic [ADDR_W-1:0] trn_pc,
  output logic              trn_taken,
  output logic [ADDR_W-1:0] trn_target,
  output logic              trn_ind,
  output logic              trn_squash,
  output logic              btb_valid,
  output logic [ADDR_W-1:0] btb_pc,
  output logic [ADDR_W-1:0] btb_target,
  output logic              rst_valid,
  output logic [SIDX_W-1:0] rst_idx,
  output logic [ADDR_W-1:0] rst_tgt,
  output logic              pop_valid,
  output logic              align_err
);
  bphq_state_t       state;
  logic [PTR_W-1:0]  head, tail;
  logic [CNT_W-1:0]  cnt;
  logic [SEQ_W-1:0]  lat_seq;
  logic              lat_mis, lat_taken;
  logic [ADDR_W-1:0] lat_tgt;

  logic not_empty, old_hit, yng_hit, fix_match, ins_fire;

  always_comb begin
    not_empty = (cnt != '0);
    old_hit   = not_empty && (old_seq <= lat_seq);
    yng_hit   = not_empty && (yng_seq > lat_seq);
    fix_match = not_empty && (yng_seq == lat_seq);
    busy      = (state != ST_IDLE);
    ins_ready = !busy && (cnt != CNT_W'(DEPTH)) && !sq_valid && !cmt_valid;
    ins_fire  = ins_valid && ins_ready;
    old_ptr   = head;
    yng_ptr   = tail - PTR_W'(1);
    wr_en     = ins_fire;
    wr_ptr    = tail;
    fix_en    = (state == ST_FIX) && fix_match;
    fix_ptr   = yng_ptr;
    fix_taken = lat_taken;
    fix_target = lat_tgt;
    // Taken: a return that skipped the stack now counts as having used it.
    // Not taken: undo whichever stack action the guess made.
    fix_used   = lat_taken ? (yng_used | yng_ret) : 1'b0;
    fix_pushed = (lat_taken || yng_used) ? yng_pushed : (yng_pushed & ~yng_call);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      head <= '0; tail <= '0; cnt <= '0;
      lat_seq <= '0; lat_mis <= 1'b0; lat_taken <= 1'b0; lat_tgt <= '0;
      trn_valid <= 1'b0; trn_pc <= '0; trn_taken <= 1'b0; trn_target <= '0;
      trn_ind <= 1'b0; trn_squash <= 1'b0;
      btb_valid <= 1'b0; btb_pc <= '0; btb_target <= '0;
      rst_valid <= 1'b0; rst_idx <= '0; rst_tgt <= '0;
      pop_valid <= 1'b0; align_err <= 1'b0;
    end else begin
      trn_valid <= 1'b0;
      btb_valid <= 1'b0;
      rst_valid <= 1'b0;
      pop_valid <= 1'b0;
      align_err <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (sq_valid) begin
            lat_seq <= sq_seq; lat_mis <= sq_mispred;
            lat_taken <= sq_taken; lat_tgt <= sq_target;
            state <= ST_SQUASH;
          end else if (cmt_valid) begin
            lat_seq <= cmt_seq;
            state <= ST_COMMIT;
          end else if (ins_fire) begin
            tail <= tail + PTR_W'(1);
            cnt  <= cnt + CNT_W'(1);
          end
        end
        ST_COMMIT: begin
          if (old_hit) begin
            trn_valid <= 1'b1; trn_pc <= old_pc; trn_taken <= old_taken;
            trn_target <= old_target; trn_ind <= old_ind; trn_squash <= 1'b0;
            head <= head + PTR_W'(1);
            cnt  <= cnt - CNT_W'(1);
          end else begin
            state <= ST_IDLE;
          end
        end
        ST_SQUASH: begin
          if (yng_hit) begin
            if (yng_used) begin
              rst_valid <= 1'b1; rst_idx <= yng_idx; rst_tgt <= yng_stgt;
            end else if (yng_call && yng_pushed) begin
              pop_valid <= 1'b1;
            end
            tail <= yng_ptr;
            cnt  <= cnt - CNT_W'(1);
          end else begin
            state <= lat_mis ? ST_FIX : ST_IDLE;
          end
        end
        ST_FIX: begin
          state <= ST_IDLE;
          if (not_empty && !fix_match) begin
            align_err <= 1'b1;
          end else if (fix_match) begin
            trn_valid <= 1'b1; trn_pc <= yng_pc; trn_taken <= lat_taken;
            trn_target <= lat_tgt; trn_ind <= yng_ind; trn_squash <= 1'b1;
            if (lat_taken) begin
              btb_valid <= 1'b1; btb_pc <= yng_pc; btb_target <= lat_tgt;
            end else if (yng_used) begin
              rst_valid <= 1'b1; rst_idx <= yng_idx; rst_tgt <= yng_stgt;
            end else if (yng_call && yng_pushed) begin
              pop_valid <= 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  a_r2_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_W'(DEPTH)) |-> !ins_ready);
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(DEPTH));
  a_r10_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ins_ready);
  a_r3_commit_train: assert property (@(posedge clk) disable iff (!rst_n)
    (trn_valid && !trn_squash) |-> ($past(state) == ST_COMMIT));
  a_r4_one_stack_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_valid && pop_valid));
  a_r4_squash_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SQUASH) |=> (cnt <= $past(cnt)));
  a_r6_btb_paired: assert property (@(posedge clk) disable iff (!rst_n)
    btb_valid |-> (trn_valid && trn_squash && trn_taken));
  a_r8_err_alone: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> (!trn_valid && !btb_valid && !rst_valid && !pop_valid));
endmodule

// File: rtl/bp_hist_queue.sv
module bp_hist_queue
  import bphq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  output logic              ins_ready,
  input  logic [SEQ_W-1:0]  ins_seq,
  input  logic [ADDR_W-1:0] ins_pc,
  input  logic              ins_taken,
  input  logic [ADDR_W-1:0] ins_target,
  input  logic              ins_call,
  input  logic              ins_ret,
  input  logic              ins_ind,
  input  logic              ins_used_stk,
  input  logic              ins_pushed_stk,
  input  logic [SIDX_W-1:0] ins_stk_idx,
  input  logic [ADDR_W-1:0] ins_stk_tgt,
  input  logic              cmt_valid,
  input  logic [SEQ_W-1:0]  cmt_seq,
  input  logic              sq_valid,
  input  logic [SEQ_W-1:0]  sq_seq,
  input  logic              sq_mispred,
  input  logic              sq_taken,
  input  logic [ADDR_W-1:0] sq_target,
  output logic              busy,
  output logic              trn_valid,
  output logic [ADDR_W-1:0] trn_pc,
  output logic              trn_taken,
  output logic [ADDR_W-1:0] trn_target,
  output logic              trn_ind,
  output logic              trn_squash,
  output logic              btb_valid,
  output logic [ADDR_W-1:0] btb_pc,
  output logic [ADDR_W-1:0] btb_target,
  output logic              rst_valid,
  output logic [SIDX_W-1:0] rst_idx,
  output logic [ADDR_W-1:0] rst_tgt,
  output logic              pop_valid,
  output logic              align_err
);
  bphq_entry_t       wr_entry;
  logic              wr_en, fix_en, fix_taken, fix_used, fix_pushed;
  logic [PTR_W-1:0]  wr_ptr, fix_ptr, old_ptr, yng_ptr;
  logic [ADDR_W-1:0] fix_target;
  logic [SEQ_W-1:0]  old_seq, yng_seq;
  logic [ADDR_W-1:0] old_pc, old_target, yng_pc, yng_stgt;
  logic              old_taken, old_ind;
  logic              yng_call, yng_ret, yng_ind, yng_used, yng_pushed;
  logic [SIDX_W-1:0] yng_idx;

  always_comb begin
    wr_entry.seq        = ins_seq;
    wr_entry.pc         = ins_pc;
    wr_entry.taken      = ins_taken;
    wr_entry.target     = ins_target;
    wr_entry.is_call    = ins_call;
    wr_entry.is_ret     = ins_ret;
    wr_entry.is_ind     = ins_ind;
    wr_entry.used_stk   = ins_used_stk;
    wr_entry.pushed_stk = ins_pushed_stk;
    wr_entry.stk_idx    = ins_stk_idx;
    wr_entry.stk_tgt    = ins_stk_tgt;
  end

  bphq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_ptr(wr_ptr), .wr_entry(wr_entry),
    .fix_en(fix_en), .fix_ptr(fix_ptr), .fix_taken(fix_taken),
    .fix_target(fix_target), .fix_used(fix_used), .fix_pushed(fix_pushed),
    .old_ptr(old_ptr), .old_seq(old_seq), .old_pc(old_pc),
    .old_taken(old_taken), .old_target(old_target), .old_ind(old_ind),
    .yng_ptr(yng_ptr), .yng_seq(yng_seq), .yng_pc(yng_pc),
    .yng_call(yng_call), .yng_ret(yng_ret), .yng_ind(yng_ind),
    .yng_used(yng_used), .yng_pushed(yng_pushed), .yng_idx(yng_idx),
    .yng_stgt(yng_stgt)
  );

  bphq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .cmt_valid(cmt_valid), .cmt_seq(cmt_seq),
    .sq_valid(sq_valid), .sq_seq(sq_seq), .sq_mispred(sq_mispred),
    .sq_taken(sq_taken), .sq_target(sq_target), .busy(busy),
    .wr_en(wr_en), .wr_ptr(wr_ptr), .fix_en(fix_en), .fix_ptr(fix_ptr),
    .fix_taken(fix_taken), .fix_target(fix_target), .fix_used(fix_used),
    .fix_pushed(fix_pushed),
    .old_ptr(old_ptr), .old_seq(old_seq), .old_pc(old_pc),
    .old_taken(old_taken), .old_target(old_target), .old_ind(old_ind),
    .yng_ptr(yng_ptr), .yng_seq(yng_seq), .yng_pc(yng_pc),
    .yng_call(yng_call), .yng_ret(yng_ret), .yng_ind(yng_ind),
    .yng_used(yng_used), .yng_pushed(yng_pushed), .yng_idx(yng_idx),
    .yng_stgt(yng_stgt),
    .trn_valid(trn_valid), .trn_pc(trn_pc), .trn_taken(trn_taken),
    .trn_target(trn_target), .trn_ind(trn_ind), .trn_squash(trn_squash),
    .btb_valid(btb_valid), .btb_pc(btb_pc), .btb_target(btb_target),
    .rst_valid(rst_valid), .rst_idx(rst_idx), .rst_tgt(rst_tgt),
    .pop_valid(pop_valid), .align_err(align_err)
  );
endmodule

// File: tb/test_bp_hist_queue.sv
`timescale 1ns/1ps
module test_bp_hist_queue;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, ins_valid, ins_ready, ins_taken, ins_call, ins_ret, ins_ind;
  logic ins_used_stk, ins_pushed_stk, cmt_valid, sq_valid, sq_mispred, sq_taken;
  logic [15:0] ins_seq, cmt_seq, sq_seq;
  logic [31:0] ins_pc, ins_target, ins_stk_tgt, sq_target;
  logic [3:0]  ins_stk_idx;
  logic busy, trn_valid, trn_taken, trn_ind, trn_squash, btb_valid, rst_valid, pop_valid, align_err;
  logic [31:0] trn_pc, trn_target, btb_pc, btb_target, rst_tgt;
  logic [3:0]  rst_idx;

  bp_hist_queue i_bp_hist_queue (.*);

  int n_tests = 0, n_fail = 0;

  // Event log filled by the monitor.
  logic [31:0] t_pc [1024]; logic [31:0] t_tgt [1024]; logic t_tk [1024]; logic t_sq [1024];
  logic [1:0]  s_kind [1024]; logic [3:0] s_idx [1024]; logic [31:0] s_tgt [1024];
  logic [31:0] b_pc [1024]; logic [31:0] b_tgt [1024];
  int t_n = 0, s_n = 0, b_n = 0, e_n = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (trn_valid) begin
        t_pc[t_n % 1024] = trn_pc; t_tgt[t_n % 1024] = trn_target;
        t_tk[t_n % 1024] = trn_taken; t_sq[t_n % 1024] = trn_squash; t_n++;
      end
      if (rst_valid || pop_valid) begin
        s_kind[s_n % 1024] = rst_valid ? 2'd1 : 2'd2;
        s_idx[s_n % 1024] = rst_idx; s_tgt[s_n % 1024] = rst_tgt; s_n++;
      end
      if (btb_valid) begin
        b_pc[b_n % 1024] = btb_pc; b_tgt[b_n % 1024] = btb_target; b_n++;
      end
      if (align_err) e_n++;
    end
  end

  // Reference model, oldest record at index 0.
  logic [15:0] m_seq [32]; logic [31:0] m_pc [32]; logic [31:0] m_tgt [32]; logic [31:0] m_stgt [32];
  logic m_tk [32]; logic m_call [32]; logic m_ret [32]; logic m_used [32]; logic m_push [32];
  logic [3:0] m_idx [32];
  int m_n = 0;

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Record fields derived from the sequence number.
  task automatic drive_rec(input logic [15:0] s);
    ins_seq = s; ins_pc = {16'h4000, s}; ins_taken = s[1];
    ins_target = {16'h4000, s} + 32'd8; ins_call = s[0]; ins_ret = ~s[0] & s[1];
    ins_ind = s[2]; ins_used_stk = s[2]; ins_pushed_stk = s[3] | s[0];
    ins_stk_idx = s[3:0] ^ 4'h5; ins_stk_tgt = {16'hB000, s};
  endtask

  task automatic ins(input logic [15:0] s);
    @(negedge clk);
    drive_rec(s); ins_valid = 1'b1;
    while (!ins_ready) @(negedge clk);
    @(negedge clk);
    ins_valid = 1'b0;
    m_seq[m_n] = s; m_pc[m_n] = ins_pc; m_tk[m_n] = ins_taken; m_tgt[m_n] = ins_target;
    m_call[m_n] = ins_call; m_ret[m_n] = ins_ret; m_used[m_n] = ins_used_stk;
    m_push[m_n] = ins_pushed_stk; m_idx[m_n] = ins_stk_idx; m_stgt[m_n] = ins_stk_tgt;
    m_n++;
  endtask

  task automatic wait_walk();
    chk("R10", "busy during walk", {63'd0, busy}, 64'd1);
    chk("R10", "ins_ready during walk", {63'd0, ins_ready}, 64'd0);
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_commit(input logic [15:0] done);
    int tb0 = t_n, sb0 = s_n, bb0 = b_n, k = 0;
    @(negedge clk); cmt_valid = 1'b1; cmt_seq = done;
    @(negedge clk); cmt_valid = 1'b0;
    wait_walk();
    while (m_n > 0 && m_seq[0] <= done) begin
      chk("R3", "train pc", {32'd0, t_pc[(tb0+k)%1024]}, {32'd0, m_pc[0]});
      chk("R3", "train taken", {63'd0, t_tk[(tb0+k)%1024]}, {63'd0, m_tk[0]});
      chk("R3", "train target", {32'd0, t_tgt[(tb0+k)%1024]}, {32'd0, m_tgt[0]});
      chk("R3", "train squash flag", {63'd0, t_sq[(tb0+k)%1024]}, 64'd0);
      for (int i = 0; i < m_n - 1; i++) begin
        m_seq[i] = m_seq[i+1]; m_pc[i] = m_pc[i+1]; m_tk[i] = m_tk[i+1]; m_tgt[i] = m_tgt[i+1];
        m_call[i] = m_call[i+1]; m_ret[i] = m_ret[i+1]; m_used[i] = m_used[i+1];
        m_push[i] = m_push[i+1]; m_idx[i] = m_idx[i+1]; m_stgt[i] = m_stgt[i+1];
      end
      m_n--; k++;
    end
    chk("R3", "retired count", 64'(t_n - tb0), 64'(k));
    chk("R3", "no stack or btb on commit", 64'((s_n - sb0) + (b_n - bb0)), 64'd0);
  endtask

  task automatic do_squash(input logic [15:0] sq, input logic mis, input logic tk, input logic [31:0] tg);
    int tb0 = t_n, sb0 = s_n, bb0 = b_n, eb0 = e_n, k = 0, et = 0, eb = 0, ee = 0;
    @(negedge clk); sq_valid = 1'b1; sq_seq = sq; sq_mispred = mis; sq_taken = tk; sq_target = tg;
    @(negedge clk); sq_valid = 1'b0;
    wait_walk();
    while (m_n > 0 && m_seq[m_n-1] > sq) begin
      int j = m_n - 1;
      if (m_used[j]) begin
        chk("R4", "restore kind", {62'd0, s_kind[(sb0+k)%1024]}, 64'd1);
        chk("R4", "restore idx", {60'd0, s_idx[(sb0+k)%1024]}, {60'd0, m_idx[j]});
        chk("R4", "restore tgt", {32'd0, s_tgt[(sb0+k)%1024]}, {32'd0, m_stgt[j]});
        k++;
      end else if (m_call[j] && m_push[j]) begin
        chk("R4", "undo-push kind", {62'd0, s_kind[(sb0+k)%1024]}, 64'd2);
        k++;
      end
      m_n--;
    end
    if (mis) begin
      if (m_n == 0) begin
        chk("R9", "empty mispredict silent", 64'((t_n - tb0) + (b_n - bb0) + (e_n - eb0)), 64'd0);
      end else if (m_seq[m_n-1] != sq) begin
        ee = 1;
      end else begin
        int j = m_n - 1;
        m_tk[j] = tk; m_tgt[j] = tg; et = 1;
        chk("R5", "fix train pc", {32'd0, t_pc[tb0%1024]}, {32'd0, m_pc[j]});
        chk("R5", "fix train taken", {63'd0, t_tk[tb0%1024]}, {63'd0, tk});
        chk("R5", "fix train target", {32'd0, t_tgt[tb0%1024]}, {32'd0, tg});
        chk("R5", "fix train squash flag", {63'd0, t_sq[tb0%1024]}, 64'd1);
        if (tk) begin
          eb = 1;
          chk("R6", "btb pc", {32'd0, b_pc[bb0%1024]}, {32'd0, m_pc[j]});
          chk("R6", "btb target", {32'd0, b_tgt[bb0%1024]}, {32'd0, tg});
          if (m_ret[j] && !m_used[j]) m_used[j] = 1'b1;
        end else if (m_used[j]) begin
          chk("R7", "fix restore kind", {62'd0, s_kind[(sb0+k)%1024]}, 64'd1);
          chk("R7", "fix restore idx", {60'd0, s_idx[(sb0+k)%1024]}, {60'd0, m_idx[j]});
          m_used[j] = 1'b0; k++;
        end else if (m_call[j] && m_push[j]) begin
          chk("R7", "fix undo-push kind", {62'd0, s_kind[(sb0+k)%1024]}, 64'd2);
          m_push[j] = 1'b0; k++;
        end
      end
    end
    chk("R4", "stack command count", 64'(s_n - sb0), 64'(k));
    chk("R5", "train count", 64'(t_n - tb0), 64'(et));
    chk("R6", "btb count", 64'(b_n - bb0), 64'(eb));
    chk("R8", "align error count", 64'(e_n - eb0), 64'(ee));
  endtask

  task automatic run_all();
    logic [15:0] nxt = 16'h8000;
    rst_n = 1'b0; ins_valid = 0; cmt_valid = 0; sq_valid = 0; sq_mispred = 0; sq_taken = 0;
    cmt_seq = 0; sq_seq = 0; sq_target = 0; drive_rec(16'h0);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "ins_ready after reset", {63'd0, ins_ready}, 64'd1);
    chk("R1", "busy after reset", {63'd0, busy}, 64'd0);
    chk("R1", "command valids after reset",
        {59'd0, trn_valid, btb_valid, rst_valid, pop_valid, align_err}, 64'd0);
    // Fill, then offer one more record while full.
    for (int i = 0; i < 16; i++) begin ins(nxt); nxt += 16'd3; end
    @(negedge clk); drive_rec(nxt); ins_valid = 1'b1;
    chk("R2", "ins_ready when full", {63'd0, ins_ready}, 64'd0);
    @(negedge clk); ins_valid = 1'b0;
    do_commit(16'h7FFF);            // below the oldest: nothing retires
    do_commit(m_seq[0] + 16'd15);   // retires six
    // Sweep squash points across a full queue.
    for (int r = 0; r < 16; r++) begin
      int pos;
      logic [15:0] sq;
      while (m_n < 16) begin ins(nxt); nxt += 16'd3; end
      pos = (r * 5) % 16;
      sq = m_seq[pos] + ((r == 7) ? 16'd1 : 16'd0);
      do_squash(sq, (r % 3) != 2, r[0], 32'hC000_0000 + 32'(r));
      if (r[1] && m_n > 0) do_squash(m_seq[m_n-1] - 16'd1, 1'b0, 1'b0, 32'd0);
      if (m_n > 0) do_commit(m_seq[0] + 16'd6);
      else do_commit(16'd0);
    end
    do_commit(16'hFFFF);
    ins(nxt); nxt += 16'd3; ins(nxt);
    do_squash(16'd0, 1'b1, 1'b1, 32'h1234_5678);   // everything removed
    do_squash(16'd0, 1'b1, 1'b0, 32'h0);           // already empty
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        n_fail++; n_tests++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule